// File: doc/BRIEF.md
# Read-After-Write Block Rewrite Sequencer

This block decides which tape block number the write formatter sends next when the check of each written block is known only while the following block is being written. The read head sits a few hundred bytes behind the write head. A block is therefore assumed good, and its successor is started without waiting for the result. Each block holds a fixed 512-byte data field, its block number and a 16-bit CRC. A file mark is an ordinary block whose data field holds a fixed pattern. The CRC itself, the channel encoding and tape motion are handled elsewhere. The block only sees a pass/fail flag that is tagged with the number of the block that was checked.

A write session starts with an inclusive range of block numbers. When the pending block fails, the block already in flight is finished first. After that the failed block and its successor are written in turn until the failed block passes, or until the retry budget is used up and a retry error is raised. The final block of the range is repeated until one copy passes. After that pass, the block waits for the check of the trailing copy and then signals completion. A check result whose tag is not the expected number raises a tag error.

Top module: `rwb_rewrite_seq`

## Requirements
- R1: After reset the block is idle. `wr_req`, `busy`, `done`, `err_retry` and `err_tag` are low and `fail_cnt` is 0.
- R2: A start pulse in the idle or error state first requests `first_num`. After that request is granted, the block requests its follower without waiting for any check result. The follower is `first_num+1`, or `first_num` again when `first_num` equals `last_num`.
- R3: While `wr_req` is high and `wr_grant` is low, `wr_req` stays high on the next cycle and `wr_num` does not change. Each cycle in which both are high counts as one written block.
- R4: After the follower is granted, no further request is raised until a check result arrives. Exactly one result is consumed per granted block.
- R5: A passing result for the pending block N, when N is not the last block, makes N+1 the pending block and clears `fail_cnt`. The next request is N+2, or N+1 again when N+1 is the last block.
- R6: A failing result for the pending block N increments `fail_cnt` and causes N to be requested again. The result for the copy of N+1 written just before that rewrite is ignored, whatever its value, and N+1 is requested after the rewrite.
- R7: Every request carries either the pending block number (`chk_num`) or `chk_num+1`.
- R8: The last block is repeated until one copy passes, so it is written at least twice. Once the check for the trailing copy arrives, `done` pulses for one cycle and the block returns to idle.
- R9: The failure that brings `fail_cnt` to RETRY_MAX (16 by default) sets `err_retry`. From then on no request is raised until a new start.
- R10: When waiting, a check result whose tag differs from the number granted two grants earlier sets `err_tag` and stops the session. After the final pass, the tag must equal the trailing copy's number, or the same happens.
- R11: `wr_repeat` is high with a request whose number was already granted in the current session, and low otherwise.
- R12: A start while in the error state clears both error flags and `fail_cnt` and begins a new session.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a session (accepted when idle or in error) |
| first_num | input | NUM_W | First block number of the session |
| last_num | input | NUM_W | Last block number of the session (inclusive) |
| wr_req | output | 1 | A block number is offered to the formatter |
| wr_num | output | NUM_W | Block number to write |
| wr_repeat | output | 1 | The offered number was already written in this session |
| wr_grant | input | 1 | Formatter takes the offered block |
| vfy_valid | input | 1 | A check result is presented |
| vfy_num | input | NUM_W | Block number the result belongs to |
| vfy_pass | input | 1 | 1 = CRC good, 0 = CRC bad |
| busy | output | 1 | Session in progress |
| done | output | 1 | One-cycle pulse at session completion |
| err_retry | output | 1 | Retry budget exhausted (held until next start) |
| err_tag | output | 1 | Result tag mismatch (held until next start) |
| chk_num | output | NUM_W | Block whose result currently decides progress |
| fail_cnt | output | CNT_W | Failures counted for the pending block |

## Verification
The assertions assume that `last_num` is not below `first_num` and that block numbers do not wrap inside a session. They also assume that check results arrive only in the waiting states, one result per granted block after the first. The stimulus follows these rules. Each result is driven only after the matching grant, and its tag is computed from the bench's own record of grants. The only exception is the single deliberate tag mismatch used for the tag-error case.

// File: rtl/rwb_pkg.sv
package rwb_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ISSUE,
        S_WAIT,
        S_DRAIN,
        S_ERR
    } rwb_state_e;

    typedef enum logic [1:0] {
        V_SKIP,
        V_PASS,
        V_FAIL,
        V_BADTAG
    } vfy_kind_e;

    typedef struct packed {
        logic done;
        logic err_retry;
        logic err_tag;
    } rwb_flags_t;

    // Sort an incoming check result: wrong tag, copy not under check, or a verdict.
    function automatic vfy_kind_e classify(input logic tag_ok,
                                           input logic is_pending,
                                           input logic pass);
        if (!tag_ok)
            return V_BADTAG;
        if (!is_pending)
            return V_SKIP;
        return pass ? V_PASS : V_FAIL;
    endfunction

endpackage

// File: rtl/rwb_issue_hist.sv
// Remembers the last two granted block numbers and the highest one granted.
module rwb_issue_hist #(
    parameter int NUM_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             take,
    input  logic [NUM_W-1:0] num,
    output logic [NUM_W-1:0] prev_num,
    output logic [NUM_W-1:0] cur_num,
    output logic             seen
);
    logic [NUM_W-1:0] prev_q, cur_q, hi_q;
    logic             hv_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            prev_q <= '0;
            cur_q  <= '0;
            hi_q   <= '0;
            hv_q   <= 1'b0;
        end else if (take) begin
            prev_q <= cur_q;
            cur_q  <= num;
            hv_q   <= 1'b1;
            if (!hv_q || num > hi_q)
                hi_q <= num;
        end
    end

    assign prev_num = prev_q;
    assign cur_num  = cur_q;
    assign seen     = hv_q && (num <= hi_q);

endmodule

// File: rtl/rwb_fail_ctr.sv
// Counts failed checks of the pending block against the retry budget.
module rwb_fail_ctr #(
    parameter int RETRY_MAX = 16,
    parameter int CNT_W     = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt,
    output logic             at_last
);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(RETRY_MAX);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt_q <= '0;
        else if (inc && cnt_q != LIMIT)
            cnt_q <= cnt_q + 1'b1;
    end

    assign cnt     = cnt_q;
    assign at_last = (cnt_q == LIMIT - 1'b1);

    // R9: the count never passes the budget
    a_r9_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LIMIT);

endmodule

// File: rtl/rwb_rewrite_seq.sv
module rwb_rewrite_seq
    import rwb_pkg::*;
#(
    parameter int NUM_W     = 16,
    parameter int RETRY_MAX = 16,
    localparam int CNT_W    = $clog2(RETRY_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [NUM_W-1:0] first_num,
    input  logic [NUM_W-1:0] last_num,
    output logic             wr_req,
    output logic [NUM_W-1:0] wr_num,
    output logic             wr_repeat,
    input  logic             wr_grant,
    input  logic             vfy_valid,
    input  logic [NUM_W-1:0] vfy_num,
    input  logic             vfy_pass,
    output logic             busy,
    output logic             done,
    output logic             err_retry,
    output logic             err_tag,
    output logic [NUM_W-1:0] chk_num,
    output logic [CNT_W-1:0] fail_cnt
);
    rwb_state_e       state_q;
    logic [NUM_W-1:0] chk_q, last_q, nxt_q;
    logic             first_q;
    rwb_flags_t       flags_q;

    logic [NUM_W-1:0] chk_p1, chk_p2, prev_num, cur_num;
    logic             seen, at_last, take, start_ok, in_wait;
    vfy_kind_e        kind;

    assign chk_p1   = chk_q + NUM_W'(1);
    assign chk_p2   = chk_q + NUM_W'(2);
    assign start_ok = start && (state_q == S_IDLE || state_q == S_ERR);
    assign take     = (state_q == S_ISSUE) && wr_grant;
    assign in_wait  = (state_q == S_WAIT) && vfy_valid;
    assign kind     = classify(vfy_num == prev_num, vfy_num == chk_q, vfy_pass);

    rwb_issue_hist #(.NUM_W(NUM_W)) hist_i (
        .clk      (clk),
        .rst      (rst),
        .clear    (start_ok),
        .take     (take),
        .num      (nxt_q),
        .prev_num (prev_num),
        .cur_num  (cur_num),
        .seen     (seen)
    );

    rwb_fail_ctr #(.RETRY_MAX(RETRY_MAX), .CNT_W(CNT_W)) fail_i (
        .clk     (clk),
        .rst     (rst),
        .clr     (start_ok || (in_wait && kind == V_PASS)),
        .inc     (in_wait && kind == V_FAIL),
        .cnt     (fail_cnt),
        .at_last (at_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            chk_q   <= '0;
            last_q  <= '0;
            nxt_q   <= '0;
            first_q <= 1'b0;
            flags_q <= '0;
        end else begin
            flags_q.done <= 1'b0;
            unique case (state_q)
                S_IDLE, S_ERR: begin
                    if (start) begin
                        chk_q             <= first_num;
                        last_q            <= last_num;
                        nxt_q             <= first_num;
                        first_q           <= 1'b1;
                        flags_q.err_retry <= 1'b0;
                        flags_q.err_tag   <= 1'b0;
                        state_q           <= S_ISSUE;
                    end
                end
                S_ISSUE: begin
                    if (wr_grant) begin
                        if (first_q) begin
                            // follower goes out before any result is known
                            first_q <= 1'b0;
                            nxt_q   <= (chk_q == last_q) ? chk_q : chk_p1;
                        end else begin
                            state_q <= S_WAIT;
                        end
                    end
                end
                S_WAIT: begin
                    if (vfy_valid) begin
                        unique case (kind)
                            V_BADTAG: begin
                                flags_q.err_tag <= 1'b1;
                                state_q         <= S_ERR;
                            end
                            V_PASS: begin
                                if (chk_q == last_q) begin
                                    state_q <= S_DRAIN;
                                end else begin
                                    chk_q   <= chk_p1;
                                    nxt_q   <= (chk_p1 == last_q) ? chk_p1 : chk_p2;
                                    state_q <= S_ISSUE;
                                end
                            end
                            V_FAIL: begin
                                if (at_last) begin
                                    flags_q.err_retry <= 1'b1;
                                    state_q           <= S_ERR;
                                end else begin
                                    nxt_q   <= chk_q;
                                    state_q <= S_ISSUE;
                                end
                            end
                            V_SKIP: begin
                                nxt_q   <= chk_p1;
                                state_q <= S_ISSUE;
                            end
                        endcase
                    end
                end
                S_DRAIN: begin
                    if (vfy_valid) begin
                        if (vfy_num != cur_num) begin
                            flags_q.err_tag <= 1'b1;
                            state_q         <= S_ERR;
                        end else begin
                            flags_q.done <= 1'b1;
                            state_q      <= S_IDLE;
                        end
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    assign wr_req    = (state_q == S_ISSUE);
    assign wr_num    = nxt_q;
    assign wr_repeat = seen;
    assign busy      = (state_q == S_ISSUE) || (state_q == S_WAIT) || (state_q == S_DRAIN);
    assign done      = flags_q.done;
    assign err_retry = flags_q.err_retry;
    assign err_tag   = flags_q.err_tag;
    assign chk_num   = chk_q;

    // R3: an offered block stays offered and unchanged until taken
    a_r3_hold_offer: assert property (@(posedge clk) disable iff (rst)
        (wr_req && !wr_grant) |=> (wr_req && $stable(wr_num)));

    // R4: no request while waiting for a missing result
    a_r4_wait_quiet: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_WAIT && !vfy_valid) |=> !wr_req);

    // R7: never more than one block beyond the pending one
    a_r7_no_skip_ahead: assert property (@(posedge clk) disable iff (rst)
        wr_req |-> (wr_num == chk_num || wr_num == chk_p1));

    // R8: completion only follows a presented result
    a_r8_done_after_result: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(vfy_valid));

    // R10: a mismatching tag while waiting stops the session
    a_r10_tag_mismatch: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_WAIT && vfy_valid && vfy_num != prev_num) |=> (err_tag && !busy));

    // R9: error kinds are exclusive and silence the request
    a_r9_err_quiet: assert property (@(posedge clk) disable iff (rst)
        !(err_retry && err_tag) && !((err_retry || err_tag) && wr_req));

endmodule

// File: tb/rwb_rewrite_seq_tb.sv
module rwb_rewrite_seq_tb_top;

    localparam int NUM_W = 16;
    localparam int RMAX  = 16;
    localparam int CW    = $clog2(RMAX + 1);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic [NUM_W-1:0] first_num = '0, last_num = '0;
    logic             wr_req, wr_repeat, busy, done, err_retry, err_tag;
    logic [NUM_W-1:0] wr_num, chk_num;
    logic             wr_grant = 1'b0;
    logic             vfy_valid = 1'b0, vfy_pass = 1'b0;
    logic [NUM_W-1:0] vfy_num = '0;
    logic [CW-1:0]    fail_cnt;

    int checks = 0, failures = 0;
    logic finished = 1'b0;
    logic [NUM_W-1:0] b_prev = '0, b_cur = '0;

    always #4 clk = ~clk;

    rwb_rewrite_seq dut_i (
        .clk(clk), .rst(rst), .start(start), .first_num(first_num), .last_num(last_num),
        .wr_req(wr_req), .wr_num(wr_num), .wr_repeat(wr_repeat), .wr_grant(wr_grant),
        .vfy_valid(vfy_valid), .vfy_num(vfy_num), .vfy_pass(vfy_pass),
        .busy(busy), .done(done), .err_retry(err_retry), .err_tag(err_tag),
        .chk_num(chk_num), .fail_cnt(fail_cnt)
    );

    typedef struct packed {
        logic             st;
        logic [NUM_W-1:0] f;
        logic [NUM_W-1:0] l;
        logic [NUM_W-1:0] exp_num;
        logic             exp_rep;
        logic             hv;
        logic             pass;
        logic [CW-1:0]    exp_fc;
        logic             dr;
    } row_t;

    // Scenario A: range 0..2, block 0 fails once. Scenario B: range 4..5, last block fails once.
    localparam row_t TABLE [10] = '{
        '{1'b1, 16'd0, 16'd2, 16'd0, 1'b0, 1'b0, 1'b0, 5'd0, 1'b0},
        '{1'b0, 16'd0, 16'd0, 16'd1, 1'b0, 1'b1, 1'b0, 5'd1, 1'b0},
        '{1'b0, 16'd0, 16'd0, 16'd0, 1'b1, 1'b1, 1'b0, 5'd1, 1'b0},
        '{1'b0, 16'd0, 16'd0, 16'd1, 1'b1, 1'b1, 1'b1, 5'd0, 1'b0},
        '{1'b0, 16'd0, 16'd0, 16'd2, 1'b0, 1'b1, 1'b1, 5'd0, 1'b0},
        '{1'b0, 16'd0, 16'd0, 16'd2, 1'b1, 1'b1, 1'b1, 5'd0, 1'b1},
        '{1'b1, 16'd4, 16'd5, 16'd4, 1'b0, 1'b0, 1'b0, 5'd0, 1'b0},
        '{1'b0, 16'd0, 16'd0, 16'd5, 1'b0, 1'b1, 1'b1, 5'd0, 1'b0},
        '{1'b0, 16'd0, 16'd0, 16'd5, 1'b1, 1'b1, 1'b0, 5'd1, 1'b0},
        '{1'b0, 16'd0, 16'd0, 16'd5, 1'b1, 1'b1, 1'b1, 5'd0, 1'b1}
    };

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_start(input logic [NUM_W-1:0] f, input logic [NUM_W-1:0] l);
        first_num = f; last_num = l; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        b_prev = '0; b_cur = '0;
    endtask

    task automatic wait_req(output logic ok);
        ok = 1'b0;
        for (int i = 0; i < 50; i++) begin
            if (wr_req) begin ok = 1'b1; break; end
            @(negedge clk);
        end
    endtask

    task automatic grant();
        b_prev = b_cur; b_cur = wr_num;
        wr_grant = 1'b1;
        @(negedge clk);
        wr_grant = 1'b0;
    endtask

    task automatic send_vfy(input logic [NUM_W-1:0] tag, input logic p);
        vfy_num = tag; vfy_pass = p; vfy_valid = 1'b1;
        @(negedge clk);
        vfy_valid = 1'b0;
    endtask

    initial begin : watchdog
        #(8 * 20000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        logic ok;
        int   n10;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check(!wr_req && !busy && !done, "R1 idle after reset", int'({wr_req, busy, done}), 0);
        check(!err_retry && !err_tag && fail_cnt == 0, "R1 flags clear", int'(fail_cnt), 0);

        // table walk: R5 R6 R7 R8 R11
        foreach (TABLE[k]) begin
            if (TABLE[k].st) do_start(TABLE[k].f, TABLE[k].l);
            wait_req(ok);
            check(ok, "R4 request expected", int'(ok), 1);
            check(wr_num == TABLE[k].exp_num, "R5/R6 order", int'(wr_num), int'(TABLE[k].exp_num));
            check(wr_repeat == TABLE[k].exp_rep, "R11 repeat flag", int'(wr_repeat), int'(TABLE[k].exp_rep));
            check(wr_num == chk_num || wr_num == chk_num + 1, "R7 within pending+1",
                  int'(wr_num), int'(chk_num));
            grant();
            if (TABLE[k].hv) begin
                send_vfy(b_prev, TABLE[k].pass);
                check(fail_cnt == TABLE[k].exp_fc, "R6 fail count", int'(fail_cnt), int'(TABLE[k].exp_fc));
            end
            if (TABLE[k].dr) begin
                check(!done && busy, "R8 no done before trailing result", int'(done), 0);
                send_vfy(b_cur, 1'b1);
                check(done, "R8 done pulse", int'(done), 1);
                @(negedge clk);
                check(!done && !busy, "R8 done one cycle then idle", int'({done, busy}), 0);
            end
        end

        // R2 R4 R8: single block session, follower without any result
        do_start(16'd7, 16'd7);
        wait_req(ok);
        check(ok && wr_num == 7, "R2 first block", int'(wr_num), 7);
        grant();
        check(wr_req && wr_num == 7, "R2 follower repeats last", int'(wr_num), 7);
        check(wr_repeat, "R11 follower marked repeat", int'(wr_repeat), 1);
        grant();
        for (int i = 0; i < 4; i++) begin
            check(!wr_req, "R4 quiet while waiting", int'(wr_req), 0);
            @(negedge clk);
        end
        send_vfy(16'd7, 1'b1);
        check(!done && busy && !wr_req, "R8 drain after last pass", int'(done), 0);
        send_vfy(16'd7, 1'b1);
        check(done, "R8 single block done", int'(done), 1);
        @(negedge clk);

        // R9: block 10 keeps failing
        do_start(16'd10, 16'd11);
        n10 = 0;
        for (int g = 0; g < 40; g++) begin
            wait_req(ok);
            if (!ok) break;
            if (wr_num == 10) n10++;
            grant();
            if (g >= 1) begin
                send_vfy(b_prev, b_prev != 16'd10);
                if (err_retry) break;
            end
        end
        check(err_retry && !err_tag, "R9 retry error", int'(err_retry), 1);
        check(fail_cnt == CW'(RMAX), "R9 fail count at limit", int'(fail_cnt), RMAX);
        check(n10 == RMAX, "R9 writes of failing block", n10, RMAX);
        repeat (3) @(negedge clk);
        check(!wr_req && !busy, "R9 no request after error", int'(wr_req), 0);

        // R12: restart out of the error state
        do_start(16'd20, 16'd20);
        check(!err_retry && !err_tag && fail_cnt == 0, "R12 flags cleared", int'(fail_cnt), 0);
        check(wr_req && wr_num == 20 && !wr_repeat, "R12 new session request", int'(wr_num), 20);

        // R10: wrong tag
        grant();
        grant();
        send_vfy(16'd21, 1'b1);
        check(err_tag && !err_retry, "R10 tag error", int'(err_tag), 1);
        check(!busy && !wr_req, "R10 session stopped", int'(busy), 0);

        finished = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule